// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Control

This block sequences a dual-modulus prescaler that divides by either P or P+1, so that the whole feedback path divides the oscillator by N = P·B + A. It is clocked by the prescaler's output, so one clock edge stands for one prescaler pulse. Two down-counters run through each feedback period. The main counter spans B prescaler pulses. The swallow counter holds the modulus-control output high, which selects P+1, for the first A of those pulses. After that the output drops and the prescaler divides by P for the remaining B − A pulses. At the last pulse of each period the block raises a one-clock feedback pulse toward the phase detector and reloads both counters from the programmed values. Because N is reached in unit steps, the output channels are spaced exactly by the phase-detector frequency.

A counter-reset input and a power-down input each force both counters to their load values and keep them there. Counting resumes with a fresh period on the first clock after both inputs are released. The ratio select only picks P (4, 8 or 16). The block checks it together with A and B and raises a configuration-error flag when the combination cannot divide as intended: A larger than B, B below 3, or the reserved ratio code.

Top module: `swallow_divider`

## Requirements
- R1: The number of oscillator cycles in one feedback period, summed as P+1 per clock with `mod_ctl` high and P per clock with it low, equals P·B + A, where `ratio_sel` 0, 1, 2 gives P = 4, 8, 16.
- R2: `fb_pulse` is high for exactly one clock, in the last clock of each period, and each period lasts exactly B clocks.
- R3: `mod_ctl` is high (select P+1) for the first A clocks of a period and low for the remaining B − A clocks.
- R4: With A = 0, `mod_ctl` stays low for the whole period.
- R5: With A = B, `mod_ctl` stays high for the whole period.
- R6: While `cnt_clear` is high, both counters hold their load values: `fb_pulse` is low and `mod_ctl` equals (A ≠ 0). The clock in which `cnt_clear` is first seen low is the first clock of a full period.
- R7: `pwr_down` behaves as in R6 and also abandons a period already in progress, so a full B-clock period follows its release.
- R8: B and A are taken only when a period starts. A change in the middle of a period leaves the current period's length unchanged and takes effect in the next period.
- R9: `cfg_err` is high when A > B, when B < 3, or when `ratio_sel` = 3, and low otherwise. It is combinational from the inputs.
- R10: While `rst_n` is low, `fb_pulse` and `mod_ctl` are low. The first clock after release, with both hold inputs low, loads the counters without a feedback pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output; one edge per prescaler pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_val | input | 12 | Main count B (legal 3 to 4095) |
| a_val | input | 6 | Swallow count A (0 to 63, not above B) |
| ratio_sel | input | 2 | Prescaler ratio: 0 = 4/5, 1 = 8/9, 2 = 16/17, 3 reserved |
| cnt_clear | input | 1 | Counter reset: hold both counters at load values |
| pwr_down | input | 1 | Power-down: hold both counters at load values |
| mod_ctl | output | 1 | High selects P+1, low selects P |
| fb_pulse | output | 1 | One-clock pulse per N oscillator cycles |
| cfg_err | output | 1 | Illegal combination of A, B and ratio select |

## Verification
The assertions assume B is at least 2 whenever a feedback pulse is checked, since a one-pulse period would legally pulse in every clock. They also assume that A changes only together with a reload when the zero-swallow case is checked. The stimulus applies only legal configurations while it measures periods. It changes B and A only at points where the old and new values are both legal, and it drives illegal combinations only in the static flag checks.

// File: rtl/swd_pkg.sv
package swd_pkg;

  // Prescaler ratio selection; the counter pair itself is ratio-agnostic.
  typedef enum logic [1:0] {
    RATIO_4  = 2'd0,
    RATIO_8  = 2'd1,
    RATIO_16 = 2'd2,
    RATIO_RSV = 2'd3
  } ratio_e;

  localparam int unsigned RATIO_W = 2;

endpackage

// File: rtl/swd_main_counter.sv
module swd_main_counter #(
  parameter int unsigned B_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_i,
  input  logic [B_W-1:0] b_val_i,
  output logic           term_o,
  output logic           load_o
);

  localparam logic [B_W-1:0] ONE = B_W'(1);

  logic [B_W-1:0] cnt_q;
  logic           at_end;

  // Zero only after reset; one is the last pulse of a period.
  assign at_end = (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (hold_i)  cnt_q <= b_val_i;
    else if (at_end)  cnt_q <= b_val_i;
    else              cnt_q <= cnt_q - ONE;
  end

  assign term_o = (cnt_q == ONE) && !hold_i;
  assign load_o = hold_i || at_end;

  AST_HOLD_LOADS_B: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == $past(b_val_i)));                       // R6

  AST_FB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (term_o && (b_val_i >= B_W'(2))) |=> !term_o);                // R2

endmodule

// File: rtl/swd_swallow_counter.sv
module swd_swallow_counter #(
  parameter int unsigned A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           hold_i,
  input  logic [A_W-1:0] a_val_i,
  output logic           mod_o
);

  logic [A_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= a_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - A_W'(1);
  end

  assign mod_o = (cnt_q != '0);

  AST_MOD_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_o) |-> $past(load_i));                              // R3

  AST_HOLD_LOADS_A: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == $past(a_val_i)));                        // R7

endmodule

// File: rtl/swd_cfg_check.sv
module swd_cfg_check
  import swd_pkg::*;
#(
  parameter int unsigned B_W   = 12,
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_MIN = 3
) (
  input  logic [B_W-1:0]     b_val_i,
  input  logic [A_W-1:0]     a_val_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               err_o
);

  localparam int unsigned PAD = B_W - A_W;

  logic [B_W-1:0] a_wide;
  logic           swallow_too_long;
  logic           main_too_short;
  logic           ratio_bad;

  assign a_wide           = {{PAD{1'b0}}, a_val_i};
  assign swallow_too_long = (a_wide > b_val_i);
  assign main_too_short   = (b_val_i < B_W'(B_MIN));
  assign ratio_bad        = (ratio_e'(ratio_i) == RATIO_RSV);
  assign err_o            = swallow_too_long || main_too_short || ratio_bad;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int unsigned B_W   = 12,
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  input  logic [1:0]     ratio_sel,
  input  logic           cnt_clear,
  input  logic           pwr_down,
  output logic           mod_ctl,
  output logic           fb_pulse,
  output logic           cfg_err
);

  logic hold;
  logic period_load;

  assign hold = cnt_clear || pwr_down;

  swd_main_counter #(.B_W(B_W)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold),
    .b_val_i (b_val),
    .term_o  (fb_pulse),
    .load_o  (period_load)
  );

  swd_swallow_counter #(.A_W(A_W)) u_swallow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (period_load),
    .hold_i  (hold),
    .a_val_i (a_val),
    .mod_o   (mod_ctl)
  );

  swd_cfg_check #(.B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)) u_cfg (
    .b_val_i (b_val),
    .a_val_i (a_val),
    .ratio_i (ratio_sel),
    .err_o   (cfg_err)
  );

  AST_ZERO_A_NO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && (a_val == '0)) |=> !mod_ctl);                    // R4

endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  // {ratio_sel[1:0], B[11:0], A[5:0]}
  localparam logic [19:0] VEC [0:5] = '{
    {2'd0, 12'd3,    6'd0},
    {2'd0, 12'd3,    6'd3},
    {2'd1, 12'd10,   6'd4},
    {2'd2, 12'd12,   6'd7},
    {2'd0, 12'd64,   6'd63},
    {2'd2, 12'd4095, 6'd63}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_val = 12'd5;
  logic [5:0]  a_val = 6'd2;
  logic [1:0]  ratio_sel = 2'd0;
  logic        cnt_clear = 1'b0;
  logic        pwr_down = 1'b0;
  logic        mod_ctl, fb_pulse, cfg_err;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst_n(rst_n), .b_val(b_val), .a_val(a_val),
    .ratio_sel(ratio_sel), .cnt_clear(cnt_clear), .pwr_down(pwr_down),
    .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Walk one period from its first clock; leaves the bench at the next period start.
  task automatic measure(input int eb, input int ea, input int p);
    int cyc = 0;
    int mods = 0;
    int n = 0;
    string mreq;
    mreq = (ea == 0) ? "R4" : ((ea == eb) ? "R5" : "R3");
    for (int i = 0; i < 5000; i++) begin
      cyc++;
      if (mod_ctl) begin
        mods++;
        n += p + 1;
      end else begin
        n += p;
      end
      if (fb_pulse) break;
      step();
    end
    check(cyc == eb, "R2", "period clocks", cyc, eb);
    check(mods == ea, mreq, "P+1 clocks", mods, ea);
    check(n == p * eb + ea, "R1", "division N", n, p * eb + ea);
    step();
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R10: reset state and first load after release
    #(CLK_PERIOD * 3 + 1);
    check(fb_pulse == 1'b0, "R10", "fb in reset", int'(fb_pulse), 0);
    check(mod_ctl == 1'b0, "R10", "mod in reset", int'(mod_ctl), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check(fb_pulse == 1'b0, "R10", "no fb on first load", int'(fb_pulse), 0);
    measure(5, 2, 4);

    // Table walk: hold, release, two full periods
    for (int v = 0; v < 6; v++) begin
      int p, b, a;
      ratio_sel = VEC[v][19:18];
      b_val     = VEC[v][17:6];
      a_val     = VEC[v][5:0];
      p = 4 << VEC[v][19:18];
      b = int'(VEC[v][17:6]);
      a = int'(VEC[v][5:0]);
      cnt_clear = 1'b1;
      step();
      step();
      check(fb_pulse == 1'b0, "R6", "fb while held", int'(fb_pulse), 0);
      check(mod_ctl == (a != 0), "R6", "mod while held", int'(mod_ctl), int'(a != 0));
      check(cfg_err == 1'b0, "R9", "legal config flag", int'(cfg_err), 0);
      cnt_clear = 1'b0;
      measure(b, a, p);
      measure(b, a, p);
    end

    // R7: power-down abandons a period in progress
    ratio_sel = 2'd1; b_val = 12'd10; a_val = 6'd4;
    cnt_clear = 1'b1; step(); step(); cnt_clear = 1'b0;
    for (int i = 0; i < 6; i++) step();
    pwr_down = 1'b1;
    step(); step();
    check(fb_pulse == 1'b0, "R7", "fb in power-down", int'(fb_pulse), 0);
    check(mod_ctl == 1'b1, "R7", "mod in power-down", int'(mod_ctl), 1);
    pwr_down = 1'b0;
    measure(10, 4, 8);

    // R8: mid-period change only applies to the next period
    ratio_sel = 2'd0; b_val = 12'd6; a_val = 6'd2;
    cnt_clear = 1'b1; step(); step(); cnt_clear = 1'b0;
    step(); step();
    b_val = 12'd9; a_val = 6'd5;
    begin
      int rem = 0;
      for (int i = 0; i < 100; i++) begin
        rem++;
        if (fb_pulse) break;
        step();
      end
      check(rem == 4, "R8", "remaining clocks of old period", rem, 4);
    end
    step();
    measure(9, 5, 4);

    // R9: configuration flag
    ratio_sel = 2'd0; b_val = 12'd4; a_val = 6'd5; #1;
    check(cfg_err == 1'b1, "R9", "A above B", int'(cfg_err), 1);
    b_val = 12'd2; a_val = 6'd0; #1;
    check(cfg_err == 1'b1, "R9", "B below 3", int'(cfg_err), 1);
    b_val = 12'd20; a_val = 6'd1; ratio_sel = 2'd3; #1;
    check(cfg_err == 1'b1, "R9", "reserved ratio", int'(cfg_err), 1);
    b_val = 12'd4; a_val = 6'd4; ratio_sel = 2'd2; #1;
    check(cfg_err == 1'b0, "R9", "A equal B", int'(cfg_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule